// File: doc/BRIEF.md
# Banked Shared-Memory Conflict Scheduler

This block takes one shared-memory read request from a 32-lane warp and works out how the request is split into conflict-free steps over a 16-bank word memory. Each lane carries an active bit and a word address. The bank of a word is its address modulo 16. The warp is handled as two half-warps: lanes 0 to 15 first, then lanes 16 to 31. Lanes from different halves never share a step, so they never count as conflicting.

In each step the block picks a broadcast word. This is the word read by the lowest-numbered unserved lane of the current half. It then picks, for every bank that still has pending lanes, the word of the lowest-numbered pending lane in that bank. Every pending lane whose address equals the word chosen for its bank is served in that step. The lanes reading the broadcast word are included in this. For each step the block presents the per-bank word selection, the bank enables and the set of lanes served. Steps are two cycles apart. When the warp is done, the block reports the number of steps, so the access time in cycles is twice that count.

Top module: `smem_conflict_sched`

## Requirements
- R1: After reset, busy_o, step_valid_o and done_o are low and step_count_o is zero.
- R2: A lane's bank is the low 4 bits of its word address. In a step, bit b of bank_en_o is set exactly when some pending lane of the current half maps to bank b.
- R3: All steps for lanes 0 to 15 come before any step for lanes 16 to 31. A step never serves lanes from both halves. step_upper_o is 1 for steps of the upper half.
- R4: step_bcast_o is the address of the lowest-numbered unserved lane in the current half. Every unserved lane of that half reading that address is served in that step.
- R5: For each enabled bank b, field b of bank_word_o (bits b*AW upward) is the address of the lowest-numbered pending lane in bank b. Every pending lane of the half whose address equals that word is served in the step. No other lane is served.
- R6: When the active lanes of a half fall in distinct banks, that half takes exactly one step.
- R7: start_i is accepted when busy_o is low. The first step is presented in the cycle after acceptance. Each further step comes two cycles after the previous one.
- R8: done_o pulses for one cycle, two cycles after the last step, or one cycle after acceptance when there are no steps. step_count_o then equals the number of steps and holds until the next accepted start.
- R9: Inactive lanes are never served. A half with no active lanes takes zero steps. A request with no active lane finishes with a count of zero.
- R10: start_i has no effect while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept a new warp request when idle |
| lane_active_i | input | 32 | Active bit per lane |
| lane_addr_i | input | 32*AW | Word address per lane, lane l in bits l*AW upward |
| busy_o | output | 1 | Request in progress |
| step_valid_o | output | 1 | A step is presented this cycle |
| step_upper_o | output | 1 | Step belongs to lanes 16 to 31 |
| step_lanes_o | output | 32 | Lanes served by this step |
| step_bcast_o | output | AW | Broadcast word of this step |
| bank_en_o | output | 16 | Banks used by this step |
| bank_word_o | output | 16*AW | Word selected per bank |
| done_o | output | 1 | One-cycle pulse when the warp is finished |
| step_count_o | output | 6 | Steps used by the current or last warp |

## Verification
The bench applies several directed patterns. Consecutive addresses spread over distinct banks and must finish in one step per half. A single shared word is served entirely by broadcast. A column of one bank forces sixteen serialized steps. A stride of two pairs lanes up in each bank. Lanes sharing words inside one bank tell broadcast merging apart from bank serialization. An all-inactive request checks the zero-step path, and a second start during a run checks that it is ignored. Pseudo-random masks and addresses then exercise mixed cases. In every case a behavioural model predicts each cycle's outputs.

// File: rtl/smem_sched_pkg.sv
package smem_sched_pkg;
  localparam int unsigned NUM_LANES  = 32;
  localparam int unsigned HALF_LANES = NUM_LANES / 2;
  localparam int unsigned NUM_BANKS  = 16;
  localparam int unsigned BANK_BITS  = $clog2(NUM_BANKS);
  localparam int unsigned LANE_IW    = $clog2(HALF_LANES);
  localparam int unsigned STEP_CW    = $clog2(NUM_LANES + 1);
endpackage

// File: rtl/smem_lane_pick.sv
module smem_lane_pick #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/smem_step_select.sv
module smem_step_select
  import smem_sched_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic [HALF_LANES-1:0]    pend_i,
  input  logic [HALF_LANES*AW-1:0] addr_i,
  output logic [HALF_LANES-1:0]    served_o,
  output logic [NUM_BANKS-1:0]     bank_en_o,
  output logic [NUM_BANKS*AW-1:0]  bank_word_o,
  output logic [AW-1:0]            bcast_o
);
  logic [AW-1:0]         addr_w [HALF_LANES];
  logic [AW-1:0]         word_w [NUM_BANKS];
  logic [LANE_IW-1:0]    lead_idx;

  for (genvar l = 0; l < HALF_LANES; l++) begin : g_unpack
    assign addr_w[l] = addr_i[l*AW +: AW];
  end

  smem_lane_pick #(.N(HALF_LANES), .IW(LANE_IW)) lead_pick_i (
    .req_i (pend_i),
    .idx_o (lead_idx)
  );
  assign bcast_o = addr_w[lead_idx];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [HALF_LANES-1:0] hit;
    logic [LANE_IW-1:0]    idx;
    for (genvar l = 0; l < HALF_LANES; l++) begin : g_hit
      assign hit[l] = pend_i[l] && (addr_w[l][BANK_BITS-1:0] == BANK_BITS'(b));
    end
    smem_lane_pick #(.N(HALF_LANES), .IW(LANE_IW)) bank_pick_i (
      .req_i (hit),
      .idx_o (idx)
    );
    assign bank_en_o[b]           = |hit;
    assign word_w[b]              = addr_w[idx];
    assign bank_word_o[b*AW +: AW] = word_w[b];
  end

  // the lead lane is lowest in its bank, so the broadcast word is covered here
  for (genvar l = 0; l < HALF_LANES; l++) begin : g_serve
    assign served_o[l] = pend_i[l] && (addr_w[l] == word_w[addr_w[l][BANK_BITS-1:0]]);
  end
endmodule

// File: rtl/smem_conflict_sched.sv
module smem_conflict_sched
  import smem_sched_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [NUM_LANES-1:0]    lane_active_i,
  input  logic [NUM_LANES*AW-1:0] lane_addr_i,
  output logic                    busy_o,
  output logic                    step_valid_o,
  output logic                    step_upper_o,
  output logic [NUM_LANES-1:0]    step_lanes_o,
  output logic [AW-1:0]           step_bcast_o,
  output logic [NUM_BANKS-1:0]    bank_en_o,
  output logic [NUM_BANKS*AW-1:0] bank_word_o,
  output logic                    done_o,
  output logic [STEP_CW-1:0]      step_count_o
);
  localparam int unsigned HAW = HALF_LANES * AW;

  logic                    busy_q, gap_q;
  logic [NUM_LANES-1:0]    pend_q;
  logic [NUM_LANES*AW-1:0] addr_q;

  logic                    upper_w;
  logic [HALF_LANES-1:0]   half_pend, half_served;
  logic [HAW-1:0]          half_addr;
  logic [NUM_LANES-1:0]    served_w;
  logic [NUM_BANKS-1:0]    sel_en;
  logic [NUM_BANKS*AW-1:0] sel_word;
  logic [AW-1:0]           sel_bcast;

  assign upper_w   = ~|pend_q[HALF_LANES-1:0];
  assign half_pend = upper_w ? pend_q[NUM_LANES-1:HALF_LANES] : pend_q[HALF_LANES-1:0];
  assign half_addr = upper_w ? addr_q[NUM_LANES*AW-1:HAW] : addr_q[HAW-1:0];
  assign served_w  = upper_w ? {half_served, {HALF_LANES{1'b0}}}
                             : {{HALF_LANES{1'b0}}, half_served};

  smem_step_select #(.AW(AW)) sel_i (
    .pend_i      (half_pend),
    .addr_i      (half_addr),
    .served_o    (half_served),
    .bank_en_o   (sel_en),
    .bank_word_o (sel_word),
    .bcast_o     (sel_bcast)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      gap_q        <= 1'b0;
      pend_q       <= '0;
      addr_q       <= '0;
      step_valid_o <= 1'b0;
      step_upper_o <= 1'b0;
      step_lanes_o <= '0;
      step_bcast_o <= '0;
      bank_en_o    <= '0;
      bank_word_o  <= '0;
      done_o       <= 1'b0;
      step_count_o <= '0;
    end else if (!busy_q) begin
      step_valid_o <= 1'b0;
      done_o       <= 1'b0;
      if (start_i) begin
        busy_q       <= 1'b1;
        gap_q        <= 1'b0;
        pend_q       <= lane_active_i;
        addr_q       <= lane_addr_i;
        step_count_o <= '0;
      end
    end else if (gap_q) begin
      gap_q        <= 1'b0;
      step_valid_o <= 1'b0;
    end else if (pend_q == '0) begin
      busy_q       <= 1'b0;
      done_o       <= 1'b1;
      step_valid_o <= 1'b0;
    end else begin
      gap_q        <= 1'b1;
      step_valid_o <= 1'b1;
      step_upper_o <= upper_w;
      step_lanes_o <= served_w;
      step_bcast_o <= sel_bcast;
      bank_en_o    <= sel_en;
      bank_word_o  <= sel_word;
      pend_q       <= pend_q & ~served_w;
      step_count_o <= step_count_o + STEP_CW'(1);
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/smem_sched_chk.sv
module smem_sched_chk
  import smem_sched_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 busy_o,
  input logic                 step_valid_o,
  input logic                 step_upper_o,
  input logic [NUM_LANES-1:0] step_lanes_o,
  input logic [AW-1:0]        step_bcast_o,
  input logic [NUM_BANKS-1:0] bank_en_o,
  input logic                 done_o,
  input logic [STEP_CW-1:0]   step_count_o,
  input logic [NUM_LANES-1:0] pend_q
);
  AST_STEP_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o |=> !step_valid_o); // R7
  AST_SINGLE_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o |-> (step_upper_o ? (step_lanes_o[HALF_LANES-1:0] == '0)
                                   : (step_lanes_o[NUM_LANES-1:HALF_LANES] == '0))); // R3
  AST_LANES_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o |-> ((step_lanes_o & ~$past(pend_q)) == '0)); // R9
  AST_STEP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o |-> (step_lanes_o != '0)); // R4
  AST_BCAST_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o |-> bank_en_o[step_bcast_o[BANK_BITS-1:0]]); // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !step_valid_o)); // R8
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(step_count_o)); // R8
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o); // R7
endmodule

bind smem_conflict_sched smem_sched_chk #(.AW(AW)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .step_valid_o (step_valid_o),
  .step_upper_o (step_upper_o),
  .step_lanes_o (step_lanes_o),
  .step_bcast_o (step_bcast_o),
  .bank_en_o    (bank_en_o),
  .done_o       (done_o),
  .step_count_o (step_count_o),
  .pend_q       (pend_q)
);

// File: tb/smem_conflict_sched_tb_top.sv
module smem_conflict_sched_tb_top;
  localparam int AW = 10;
  localparam int NL = 32;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [NL-1:0]    lane_active_i = '0;
  logic [NL*AW-1:0] lane_addr_i = '0;
  logic             busy_o, step_valid_o, step_upper_o, done_o;
  logic [NL-1:0]    step_lanes_o;
  logic [AW-1:0]    step_bcast_o;
  logic [NB-1:0]    bank_en_o;
  logic [NB*AW-1:0] bank_word_o;
  logic [5:0]       step_count_o;

  always #10 clk = ~clk;

  smem_conflict_sched #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .lane_active_i(lane_active_i), .lane_addr_i(lane_addr_i),
    .busy_o(busy_o), .step_valid_o(step_valid_o), .step_upper_o(step_upper_o),
    .step_lanes_o(step_lanes_o), .step_bcast_o(step_bcast_o),
    .bank_en_o(bank_en_o), .bank_word_o(bank_word_o),
    .done_o(done_o), .step_count_o(step_count_o)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model
  bit m_busy = 0, m_done = 0;
  int m_t = 0, m_S = 0;
  logic [NL-1:0]    q_lanes[$];
  bit               q_upper[$];
  logic [AW-1:0]    q_bcast[$];
  logic [NB-1:0]    q_en[$];
  logic [NB*AW-1:0] q_word[$];

  function automatic logic [AW-1:0] la(input int l);
    return lane_addr_i[l*AW +: AW];
  endfunction

  task automatic build();
    logic [NL-1:0] pend;
    q_lanes.delete(); q_upper.delete(); q_bcast.delete(); q_en.delete(); q_word.delete();
    pend = lane_active_i;
    for (int h = 0; h < 2; h++) begin
      while (pend[h*16 +: 16] != 0) begin
        logic [NL-1:0] srv; logic [NB-1:0] en; logic [NB*AW-1:0] wd; int lead;
        srv = '0; en = '0; wd = '0; lead = -1;
        for (int l = h*16; l < h*16+16; l++) if (pend[l] && lead < 0) lead = l;
        for (int l = h*16; l < h*16+16; l++) begin
          if (pend[l]) begin
            int bk; int first;
            bk = la(l) % NB; first = -1;
            for (int j = h*16; j < h*16+16; j++)
              if (pend[j] && (la(j) % NB) == bk && first < 0) first = j;
            en[bk] = 1'b1;
            wd[bk*AW +: AW] = la(first);
            if (la(l) == la(first)) srv[l] = 1'b1;
          end
        end
        pend = pend & ~srv;
        q_lanes.push_back(srv); q_upper.push_back(h == 1);
        q_bcast.push_back(la(lead)); q_en.push_back(en); q_word.push_back(wd);
      end
    end
    m_S = q_lanes.size();
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_t = 0; m_S = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin build(); m_busy = 1; m_t = 0; end
      end else begin
        m_t++;
        if (m_t == 2*m_S + 1) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      bit ev; int k; int ec;
      cycles++;
      ev = m_busy && (m_t % 2 == 1) && ((m_t-1)/2 < m_S);
      ec = m_busy ? (((m_t+1)/2 < m_S) ? (m_t+1)/2 : m_S) : m_S;
      chk(busy_o == m_busy, "R10", "busy", busy_o, m_busy);
      chk(step_valid_o == ev, "R7", "step_valid", step_valid_o, ev);
      chk(done_o == m_done, "R8", "done", done_o, m_done);
      chk(step_count_o == ec, "R8", "step_count", step_count_o, ec);
      if (ev && step_valid_o) begin
        k = (m_t-1)/2;
        chk(step_lanes_o == q_lanes[k], "R5", "served lanes", step_lanes_o, q_lanes[k]);
        chk(step_upper_o == q_upper[k], "R3", "half", step_upper_o, q_upper[k]);
        chk(step_bcast_o == q_bcast[k], "R4", "bcast word", step_bcast_o, q_bcast[k]);
        chk(bank_en_o == q_en[k], "R2", "bank enables", bank_en_o, q_en[k]);
        for (int b = 0; b < NB; b++)
          if (q_en[k][b])
            chk(bank_word_o[b*AW +: AW] == q_word[k][b*AW +: AW], "R5", "bank word",
                bank_word_o[b*AW +: AW], q_word[k][b*AW +: AW]);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 100000) begin
    chk(1'b0, "R7", "watchdog expired", cycles, 100000);
    finish_run();
  end

  task automatic run(input logic [NL-1:0] act, input int expect_s, input string req);
    @(negedge clk);
    lane_active_i = act; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!m_done) @(negedge clk);
    if (expect_s >= 0)
      chk(step_count_o == expect_s, req, "final step count", step_count_o, expect_s);
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !step_valid_o && !done_o && step_count_o == 0, "R1", "reset state",
        {busy_o, step_valid_o, done_o, step_count_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R6: consecutive words, distinct banks in each half
    for (int l = 0; l < NL; l++) lane_addr_i[l*AW +: AW] = AW'(100 + l);
    run('1, 2, "R6");
    // R4 R9: one shared word, upper half inactive
    for (int l = 0; l < NL; l++) lane_addr_i[l*AW +: AW] = AW'(37);
    run(32'h0000_FFFF, 1, "R4");
    // R5: one bank, sixteen words
    for (int l = 0; l < NL; l++) lane_addr_i[l*AW +: AW] = AW'(16*l);
    run(32'h0000_FFFF, 16, "R5");
    // R2: stride two, pairs per bank
    for (int l = 0; l < NL; l++) lane_addr_i[l*AW +: AW] = AW'(2*l);
    run('1, 4, "R2");
    // R5: pairs share words inside bank 0
    for (int l = 0; l < NL; l++) lane_addr_i[l*AW +: AW] = AW'((l/2)*16);
    run(32'hFFFF_0000, 8, "R5");
    // R9: nothing active
    run('0, 0, "R9");
    // R3: only upper half active, distinct banks
    for (int l = 0; l < NL; l++) lane_addr_i[l*AW +: AW] = AW'(3*l);
    run(32'hFFFF_0000, 1, "R3");

    // R10: second start during a run is ignored
    for (int l = 0; l < NL; l++) lane_addr_i[l*AW +: AW] = AW'(16*l);
    @(negedge clk);
    lane_active_i = 32'h0000_00FF; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    lane_active_i = '1; start_i = 1'b1;
    for (int l = 0; l < NL; l++) lane_addr_i[l*AW +: AW] = AW'(l);
    @(negedge clk);
    start_i = 1'b0;
    while (!m_done) @(negedge clk);
    chk(step_count_o == 8, "R10", "count after ignored start", step_count_o, 8);

    // mixed patterns, model-predicted
    for (int r = 0; r < 12; r++) begin
      for (int l = 0; l < NL; l++) begin
        lfsr = nxt(lfsr);
        lane_addr_i[l*AW +: AW] = AW'(lfsr[9:0] % 48);
      end
      lfsr = nxt(lfsr);
      run(lfsr ^ {lfsr[15:0], lfsr[31:16]}, -1, "R5");
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule